// File: doc/BRIEF.md
# Memory-to-Memory Copy Engine with Bus Retry

This block moves a run of words from one memory region to another. Software sets a source address, a destination address and a word count through a small register window on a bus slave port, then sets the start bit. For each word, the engine reads from the source on a dedicated read master and holds the returned word. It then writes that word to the destination on a dedicated write master. Both addresses advance by one bus word and the count drops by one, until the count is exhausted.

Either target may answer with retry instead of acknowledge. The engine then releases both buses for a fixed number of clocks, set by a parameter. After that it reissues exactly the same cycle, with the same address and, for a write, the same data. An error answer from either target ends the transfer at once. The engine then records the failure in a status bit and raises the interrupt if interrupts are enabled. Normal completion is reported the same way through a separate done bit. Both bits are write-one-to-clear.

The register window uses byte offsets 0x00 source, 0x04 destination, 0x08 count, 0x0C control and 0x10 status. The data widths of the master buses and the retry wait are parameters.

Top module: `wb_copy_engine`

## Requirements
- R1: After reset both masters have cyc low, irq is low, and every register at offsets 0x00 to 0x10 reads as zero.
- R2: A slave access is acknowledged one clock after the request. Offsets 0x00, 0x04 and 0x08 read back the source, destination and count last written. At 0x0C, bit1 is interrupt enable and reads back, while bit0 (start) reads as 0. At 0x10, bit0 is busy, bit1 is done and bit2 is error.
- R3: Each transfer step reads one word at the current source address, then writes exactly that word to the current destination address. Only one master has cyc high at a time.
- R4: After each acknowledged write, source and destination advance by DATA_W/8 and the count drops by one. After the last write, busy clears, done sets and the count reads 0.
- R5: After a retry answer on either master, both masters keep cyc low for exactly RETRY_WAIT clocks. The same cycle is then reissued with an unchanged address, and for a write with unchanged data.
- R6: An error answer ends the transfer. Both cyc are low on the next clock, busy clears, error sets and done stays clear. The count keeps the number of words not yet written.
- R7: irq is high exactly when interrupt enable is set and done or error is set.
- R8: Writing 1 to status bit1 clears done and writing 1 to bit2 clears error. Writing 0 leaves them unchanged.
- R9: While busy, a start write and writes to source, destination or count have no effect on the running transfer or on those registers.
- R10: A start with a count of zero sets done at once and causes no activity on either master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sCyc | input | 1 | Control slave cycle |
| sStb | input | 1 | Control slave strobe |
| sWe | input | 1 | Control slave write enable |
| sAdr | input | 5 | Control slave byte offset |
| sDatI | input | CTRL_W | Control slave write data |
| sDatO | output | CTRL_W | Control slave read data |
| sAck | output | 1 | Control slave acknowledge |
| rdCyc | output | 1 | Read master cycle |
| rdStb | output | 1 | Read master strobe |
| rdAdr | output | ADDR_W | Read master address |
| rdDatI | input | DATA_W | Read master returned data |
| rdAck | input | 1 | Read master acknowledge |
| rdErr | input | 1 | Read master error answer |
| rdRty | input | 1 | Read master retry answer |
| wrCyc | output | 1 | Write master cycle |
| wrStb | output | 1 | Write master strobe |
| wrWe | output | 1 | Write master write enable (always 1) |
| wrAdr | output | ADDR_W | Write master address |
| wrDatO | output | DATA_W | Write master data |
| wrAck | input | 1 | Write master acknowledge |
| wrErr | input | 1 | Write master error answer |
| wrRty | input | 1 | Write master retry answer |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions watch several properties on every clock. Both buses go quiet on the clock after a retry or an error answer. The read address and the write data hold steady while a cycle is outstanding or being retried. The count drops by exactly one per acknowledged write. The error flag follows an error answer, and configuration writes during a transfer leave the registers untouched. Other behaviour only shows in the bench's scenarios: the exact length of the quiet window, the contents and order of the written words, the final register values after complete, aborted, zero-length and interrupted transfers, and the interrupt level.

// File: rtl/copy_engine_pkg.sv
package copy_engine_pkg;

  localparam int REG_ADR_W = 5;

  localparam logic [REG_ADR_W-1:0] OFS_SRC  = 5'h00;
  localparam logic [REG_ADR_W-1:0] OFS_DST  = 5'h04;
  localparam logic [REG_ADR_W-1:0] OFS_LEN  = 5'h08;
  localparam logic [REG_ADR_W-1:0] OFS_CTRL = 5'h0C;
  localparam logic [REG_ADR_W-1:0] OFS_STAT = 5'h10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_RDWAIT,
    ST_WRWAIT
  } engState_t;

  typedef struct packed {
    logic latchData;
    logic advance;
    logic setDone;
    logic setErr;
  } engStrobe_t;

endpackage

// File: rtl/copy_engine_ctrl.sv
module copy_engine_ctrl
  import copy_engine_pkg::*;
#(
  parameter int RETRY_WAIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       lenZero,
  input  logic       lenOne,
  input  logic       rdAck,
  input  logic       rdErr,
  input  logic       rdRty,
  input  logic       wrAck,
  input  logic       wrErr,
  input  logic       wrRty,
  output logic       rdCyc,
  output logic       wrCyc,
  output logic       busy,
  output engStrobe_t stb
);

  localparam int TMR_W = $clog2(RETRY_WAIT + 1);

  engState_t  state, nextState;
  logic [TMR_W-1:0] waitCnt;
  logic       loadWait;

  assign rdCyc = (state == ST_READ);
  assign wrCyc = (state == ST_WRITE);
  assign busy  = (state != ST_IDLE);

  always_comb begin
    nextState = state;
    stb       = '0;
    loadWait  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          if (lenZero) stb.setDone = 1'b1;
          else         nextState   = ST_READ;
        end
      end
      ST_READ: begin
        if (rdAck) begin
          stb.latchData = 1'b1;
          nextState     = ST_WRITE;
        end else if (rdErr) begin
          stb.setErr = 1'b1;
          nextState  = ST_IDLE;
        end else if (rdRty) begin
          loadWait  = 1'b1;
          nextState = ST_RDWAIT;
        end
      end
      ST_WRITE: begin
        if (wrAck) begin
          stb.advance = 1'b1;
          if (lenOne) begin
            stb.setDone = 1'b1;
            nextState   = ST_IDLE;
          end else begin
            nextState = ST_READ;
          end
        end else if (wrErr) begin
          stb.setErr = 1'b1;
          nextState  = ST_IDLE;
        end else if (wrRty) begin
          loadWait  = 1'b1;
          nextState = ST_WRWAIT;
        end
      end
      ST_RDWAIT: if (waitCnt == TMR_W'(1)) nextState = ST_READ;
      ST_WRWAIT: if (waitCnt == TMR_W'(1)) nextState = ST_WRITE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state <= nextState;
      if (loadWait)            waitCnt <= TMR_W'(RETRY_WAIT);
      else if (waitCnt != '0)  waitCnt <= waitCnt - 1'b1;
    end
  end

  AST_ERR_STOP: assert property (@(posedge clk) disable iff (!rstN)
    ((rdCyc && rdErr && !rdAck) || (wrCyc && wrErr && !wrAck)) |=> (!busy && !rdCyc && !wrCyc)); // R6

  AST_RETRY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((rdCyc && rdRty && !rdAck && !rdErr) || (wrCyc && wrRty && !wrAck && !wrErr)) |=> (!rdCyc && !wrCyc)); // R5

endmodule

// File: rtl/copy_engine_datapath.sv
module copy_engine_datapath
  import copy_engine_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int CTRL_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sCyc,
  input  logic                 sStb,
  input  logic                 sWe,
  input  logic [REG_ADR_W-1:0] sAdr,
  input  logic [CTRL_W-1:0]    sDatI,
  output logic [CTRL_W-1:0]    sDatO,
  output logic                 sAck,
  input  logic                 busy,
  input  engStrobe_t           stb,
  input  logic                 rdCyc,
  input  logic                 rdAck,
  input  logic                 rdErr,
  input  logic                 rdRty,
  input  logic                 wrCyc,
  input  logic                 wrAck,
  input  logic [DATA_W-1:0]    rdDatI,
  output logic [ADDR_W-1:0]    rdAdr,
  output logic [ADDR_W-1:0]    wrAdr,
  output logic [DATA_W-1:0]    wrDatO,
  output logic                 startReq,
  output logic                 lenZero,
  output logic                 lenOne,
  output logic                 irq
);

  localparam int STEP = DATA_W / 8;

  logic [ADDR_W-1:0] srcAdr, dstAdr;
  logic [LEN_W-1:0]  lenReg;
  logic [DATA_W-1:0] dataReg;
  logic              intEn, doneFlag, errFlag;
  logic              sWrite, cfgWrite;

  assign sWrite   = sCyc && sStb && sWe && !sAck;
  assign cfgWrite = sWrite && !busy;
  assign startReq = cfgWrite && (sAdr == OFS_CTRL) && sDatI[0];
  assign lenZero  = (lenReg == '0);
  assign lenOne   = (lenReg == LEN_W'(1));
  assign rdAdr    = srcAdr;
  assign wrAdr    = dstAdr;
  assign wrDatO   = dataReg;
  assign irq      = intEn && (doneFlag || errFlag);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAdr  <= '0;
      dstAdr  <= '0;
      lenReg  <= '0;
      dataReg <= '0;
    end else begin
      if (stb.advance) begin
        srcAdr <= srcAdr + ADDR_W'(STEP);
        dstAdr <= dstAdr + ADDR_W'(STEP);
        lenReg <= lenReg - 1'b1;
      end else if (cfgWrite) begin
        if (sAdr == OFS_SRC) srcAdr <= ADDR_W'(sDatI);
        if (sAdr == OFS_DST) dstAdr <= ADDR_W'(sDatI);
        if (sAdr == OFS_LEN) lenReg <= LEN_W'(sDatI);
      end
      if (stb.latchData) dataReg <= rdDatI;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEn    <= 1'b0;
      doneFlag <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (sWrite && sAdr == OFS_CTRL) intEn <= sDatI[1];
      if (stb.setDone)                                   doneFlag <= 1'b1;
      else if (sWrite && sAdr == OFS_STAT && sDatI[1])   doneFlag <= 1'b0;
      if (stb.setErr)                                    errFlag  <= 1'b1;
      else if (sWrite && sAdr == OFS_STAT && sDatI[2])   errFlag  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sAck  <= 1'b0;
      sDatO <= '0;
    end else begin
      sAck <= sCyc && sStb && !sAck;
      if (sCyc && sStb && !sAck) begin
        unique case (sAdr)
          OFS_SRC:  sDatO <= CTRL_W'(srcAdr);
          OFS_DST:  sDatO <= CTRL_W'(dstAdr);
          OFS_LEN:  sDatO <= CTRL_W'(lenReg);
          OFS_CTRL: sDatO <= CTRL_W'({intEn, 1'b0});
          OFS_STAT: sDatO <= CTRL_W'({errFlag, doneFlag, busy});
          default:  sDatO <= '0;
        endcase
      end
    end
  end

  AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (wrCyc && wrAck) |=> (lenReg == $past(lenReg) - 1'b1)); // R4

  AST_RD_ADR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdCyc && rdRty && !rdAck && !rdErr) |=> $stable(rdAdr)); // R5

  AST_WR_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrCyc && !wrAck) |=> $stable(wrDatO)); // R5

  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (rdCyc && rdErr && !rdAck) |=> errFlag); // R6

  AST_BUSY_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sWrite && sAdr == OFS_DST && !(wrCyc && wrAck)) |=> $stable(dstAdr)); // R9

endmodule

// File: rtl/wb_copy_engine.sv
module wb_copy_engine
  import copy_engine_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int CTRL_W     = 32,
  parameter int RETRY_WAIT = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sCyc,
  input  logic                 sStb,
  input  logic                 sWe,
  input  logic [REG_ADR_W-1:0] sAdr,
  input  logic [CTRL_W-1:0]    sDatI,
  output logic [CTRL_W-1:0]    sDatO,
  output logic                 sAck,
  output logic                 rdCyc,
  output logic                 rdStb,
  output logic [ADDR_W-1:0]    rdAdr,
  input  logic [DATA_W-1:0]    rdDatI,
  input  logic                 rdAck,
  input  logic                 rdErr,
  input  logic                 rdRty,
  output logic                 wrCyc,
  output logic                 wrStb,
  output logic                 wrWe,
  output logic [ADDR_W-1:0]    wrAdr,
  output logic [DATA_W-1:0]    wrDatO,
  input  logic                 wrAck,
  input  logic                 wrErr,
  input  logic                 wrRty,
  output logic                 irq
);

  engStrobe_t stb;
  logic busy, startReq, lenZero, lenOne;

  assign rdStb = rdCyc;
  assign wrStb = wrCyc;
  assign wrWe  = 1'b1;

  copy_engine_ctrl #(.RETRY_WAIT(RETRY_WAIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .lenZero(lenZero), .lenOne(lenOne),
    .rdAck(rdAck), .rdErr(rdErr), .rdRty(rdRty),
    .wrAck(wrAck), .wrErr(wrErr), .wrRty(wrRty),
    .rdCyc(rdCyc), .wrCyc(wrCyc), .busy(busy), .stb(stb)
  );

  copy_engine_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .CTRL_W(CTRL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .sCyc(sCyc), .sStb(sStb), .sWe(sWe), .sAdr(sAdr), .sDatI(sDatI),
    .sDatO(sDatO), .sAck(sAck),
    .busy(busy), .stb(stb),
    .rdCyc(rdCyc), .rdAck(rdAck), .rdErr(rdErr), .rdRty(rdRty),
    .wrCyc(wrCyc), .wrAck(wrAck),
    .rdDatI(rdDatI), .rdAdr(rdAdr), .wrAdr(wrAdr), .wrDatO(wrDatO),
    .startReq(startReq), .lenZero(lenZero), .lenOne(lenOne), .irq(irq)
  );

endmodule

// File: tb/wb_copy_engine_bench.sv
module wb_copy_engine_bench;

  localparam int RW = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sCyc = 0, sStb = 0, sWe = 0;
  logic [4:0]  sAdr = '0;
  logic [31:0] sDatI = '0;
  logic [31:0] sDatO;
  logic sAck;
  logic rdCyc, rdStb, wrCyc, wrStb, wrWe, irq;
  logic [31:0] rdAdr, wrAdr, wrDatO;
  logic [31:0] rdDatI = '0;
  logic rdAck = 0, rdErr = 0, rdRty = 0, wrAck = 0, wrErr = 0, wrRty = 0;

  always #2 clk = ~clk;

  wb_copy_engine #(.RETRY_WAIT(RW)) u_wb_copy_engine (
    .clk(clk), .rstN(rstN), .sCyc(sCyc), .sStb(sStb), .sWe(sWe), .sAdr(sAdr),
    .sDatI(sDatI), .sDatO(sDatO), .sAck(sAck),
    .rdCyc(rdCyc), .rdStb(rdStb), .rdAdr(rdAdr), .rdDatI(rdDatI),
    .rdAck(rdAck), .rdErr(rdErr), .rdRty(rdRty),
    .wrCyc(wrCyc), .wrStb(wrStb), .wrWe(wrWe), .wrAdr(wrAdr), .wrDatO(wrDatO),
    .wrAck(wrAck), .wrErr(wrErr), .wrRty(wrRty), .irq(irq)
  );

  int checks = 0, fails = 0;
  int rtyPct = 0, errRdAt = -1, errWrAt = -1;
  int rdIdx = 0, wrIdx = 0, rdDly = 0, wrDly = 0, retries = 0, busActive = 0;
  logic [31:0] curSrc = '0, curDst = '0;
  bit rdPend = 0, wrPend = 0;
  int rdLow = 0, wrLow = 0;
  logic [31:0] rdSaved, wrSavedA, wrSavedD;

  function automatic logic [31:0] srcWord(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A1234;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // bus targets, driven away from the active edge
  always @(negedge clk) begin
    rdAck = 0; rdErr = 0; rdRty = 0; wrAck = 0; wrErr = 0; wrRty = 0;
    if (rdCyc || wrCyc) busActive++;
    if (rdPend) begin
      if (rdCyc) begin
        check(rdLow == RW && rdAdr == rdSaved, "R5", "read reissue gap/addr",
              {rdLow, rdAdr}, {RW, rdSaved});
        rdPend = 0;
      end else rdLow++;
    end
    if (wrPend) begin
      if (wrCyc) begin
        check(wrLow == RW && wrAdr == wrSavedA && wrDatO == wrSavedD, "R5",
              "write reissue gap/addr/data", wrLow, RW);
        wrPend = 0;
      end else wrLow++;
    end
    if (!rdCyc) rdDly = $urandom % 3;
    else if (rdDly > 0) rdDly--;
    else begin
      if (rdIdx == errRdAt) rdErr = 1;
      else if (int'($urandom % 100) < rtyPct) begin
        rdRty = 1; rdPend = 1; rdLow = 0; rdSaved = rdAdr; retries++;
      end else begin
        rdAck = 1; rdDatI = srcWord(rdAdr); rdIdx++;
      end
    end
    if (!wrCyc) wrDly = $urandom % 3;
    else if (wrDly > 0) wrDly--;
    else begin
      if (wrIdx == errWrAt) wrErr = 1;
      else if (int'($urandom % 100) < rtyPct) begin
        wrRty = 1; wrPend = 1; wrLow = 0; wrSavedA = wrAdr; wrSavedD = wrDatO; retries++;
      end else begin
        check(wrAdr == curDst + 32'(wrIdx * 4) && wrDatO == srcWord(curSrc + 32'(wrIdx * 4)),
              "R3", "write address/data", {wrAdr, wrDatO},
              {curDst + 32'(wrIdx * 4), srcWord(curSrc + 32'(wrIdx * 4))});
        wrAck = 1; wrIdx++;
      end
    end
  end

  task automatic regWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    sCyc = 1; sStb = 1; sWe = 1; sAdr = a; sDatI = d;
    do @(negedge clk); while (!sAck);
    sCyc = 0; sStb = 0; sWe = 0;
  endtask

  task automatic regRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    sCyc = 1; sStb = 1; sWe = 0; sAdr = a;
    do @(negedge clk); while (!sAck);
    d = sDatO;
    sCyc = 0; sStb = 0;
  endtask

  task automatic waitIdle();
    logic [31:0] st;
    do regRead(5'h10, st); while (st[0]);
  endtask

  task automatic runXfer(input logic [31:0] src, input logic [31:0] dst, input int len,
                         input int pct, input int eRd, input int eWr, input bit ie);
    logic [31:0] v;
    int expW;
    logic [2:0] expSt;
    curSrc = src; curDst = dst; rtyPct = pct; errRdAt = eRd; errWrAt = eWr;
    rdIdx = 0; wrIdx = 0;
    regWrite(5'h00, src);
    regWrite(5'h04, dst);
    regWrite(5'h08, 32'(len));
    regWrite(5'h0C, {30'b0, ie, 1'b1});
    waitIdle();
    expW  = (eRd >= 0) ? eRd : (eWr >= 0) ? eWr : len;
    expSt = (eRd >= 0 || eWr >= 0) ? 3'b100 : 3'b010;
    check(wrIdx == expW, (expSt[2] ? "R6" : "R3"), "writes completed", wrIdx, expW);
    regRead(5'h10, v);
    check(v[2:0] == expSt, (expSt[2] ? "R6" : "R4"), "status", v[2:0], expSt);
    regRead(5'h08, v);
    check(v == 32'(len - expW), "R4", "count remaining", v, len - expW);
    regRead(5'h04, v);
    check(v == dst + 32'(expW * 4), "R4", "final destination", v, dst + 32'(expW * 4));
    @(negedge clk);
    check(irq == ie, "R7", "irq after end", irq, ie);
    regWrite(5'h10, 32'h0);
    regRead(5'h10, v);
    check(v[2:0] == expSt, "R8", "write 0 keeps flags", v[2:0], expSt);
    regWrite(5'h10, 32'h6);
    regRead(5'h10, v);
    @(negedge clk);
    check(v[2:0] == 3'b000 && irq == 1'b0, "R8", "flags cleared", {v[2:0], irq}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int bus0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(!rdCyc && !wrCyc && !irq, "R1", "outputs after reset", {rdCyc, wrCyc, irq}, 0);
    for (int i = 0; i < 5; i++) begin
      regRead(5'(i * 4), v);
      check(v == 0, "R1", "register after reset", v, 0);
    end

    // R2 register readback
    regWrite(5'h00, 32'h1000_0100);
    regWrite(5'h04, 32'h2000_0200);
    regWrite(5'h08, 32'h0000_0005);
    regWrite(5'h0C, 32'h2);
    regRead(5'h00, v); check(v == 32'h1000_0100, "R2", "source readback", v, 32'h1000_0100);
    regRead(5'h04, v); check(v == 32'h2000_0200, "R2", "destination readback", v, 32'h2000_0200);
    regRead(5'h08, v); check(v == 5, "R2", "count readback", v, 5);
    regRead(5'h0C, v); check(v == 2, "R2", "control readback", v, 2);

    // R10 zero count
    regWrite(5'h08, 32'h0);
    bus0 = busActive;
    regWrite(5'h0C, 32'h3);
    regRead(5'h10, v);
    check(v[2:0] == 3'b010, "R10", "zero count done", v[2:0], 3'b010);
    check(busActive == bus0, "R10", "no bus activity", busActive, bus0);
    regWrite(5'h10, 32'h6);

    // directed copies
    runXfer(32'h0000_1000, 32'h0000_8000, 1, 0, -1, -1, 1);
    runXfer(32'h0000_2000, 32'h0000_9000, 6, 40, -1, -1, 1);
    check(retries > 0, "R5", "retries exercised", retries, 1);
    runXfer(32'h0000_3000, 32'h0000_A000, 5, 0, 2, -1, 1);
    runXfer(32'h0000_4000, 32'h0000_B000, 5, 0, -1, 3, 0);
    runXfer(32'h0000_5000, 32'h0000_C000, 4, 0, 0, -1, 1);

    // R9 writes while busy
    curSrc = 32'h0000_6000; curDst = 32'h0000_D000; rtyPct = 0; errRdAt = -1; errWrAt = -1;
    rdIdx = 0; wrIdx = 0;
    regWrite(5'h00, curSrc);
    regWrite(5'h04, curDst);
    regWrite(5'h08, 32'd12);
    regWrite(5'h0C, 32'h1);
    regRead(5'h10, v);
    check(v[0] == 1'b1, "R2", "busy bit while running", v[0], 1);
    regWrite(5'h00, 32'hDEAD_0000);
    regWrite(5'h04, 32'hBEEF_0000);
    regWrite(5'h08, 32'd2);
    regWrite(5'h0C, 32'h1);
    waitIdle();
    check(wrIdx == 12, "R9", "writes despite busy writes", wrIdx, 12);
    regRead(5'h00, v);
    check(v == curSrc + 32'd48, "R9", "source unaffected", v, curSrc + 32'd48);
    regRead(5'h04, v);
    check(v == curDst + 32'd48, "R9", "destination unaffected", v, curDst + 32'd48);
    regWrite(5'h10, 32'h6);

    // random copies
    for (int n = 0; n < 12; n++) begin
      runXfer({16'h0001, 14'($urandom), 2'b00}, {16'h0002, 14'($urandom), 2'b00},
              1 + int'($urandom % 8), int'($urandom % 30), -1, -1, 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule